// File: doc/BRIEF.md
# Descriptor Ring Processing Engine

This block walks two descriptor rings, one for received frames and one for transmitted frames, that sit together in a shared 1 KB-aligned memory area. Software puts descriptors into a ring and marks each one as owned by hardware. It then writes the prompt register. Each idle ring reads its next descriptor through a single word-wide request/response memory port and keeps a cached copy. It passes the buffer address, length and control byte to a frame data path through a start/done handshake. When the data path reports done, the ring writes back the final count and status and gives ownership back to software. It then moves on to the following entry.

Each descriptor is 8 bytes. Word 0 holds a 12-bit count in bits [11:0], and bits [31:16] are reserved. Word 1 holds buffer address bits [23:0] in bits [23:0] and a status byte in bits [31:24]. Bit 7 of the status byte is the hardware-ownership flag. Memory words are little-endian, and every access is a single word. The upper address byte of every access comes from a fixed page input. A master-enable input stops both rings and clears their indices.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset, the base readback, the size readback and the pointer readback are all zero. No memory request and no start pulse is active.
- R2: The base register is written with selector 0 and takes wdata[13:0]. Every memory address has bits [31:24] equal to page_i and bits [23:10] equal to the base register.
- R3: Receive descriptor i sits at area offset 8*i. Transmit descriptor i sits at offset 512 + 8*i. Word 1 of a descriptor is read at +4.
- R4: The size register is written with selector 1. The transmit code is in wdata[15:12] and the receive code is in wdata[11:8]. The codes 0000, 0001, 0011, 0111 and 1111 select 4, 8, 16, 32 and 64 entries. After the last entry, the index wraps to 0.
- R5: The pointer readback holds the receive index in [5:0] and the transmit index in [13:8]. All other bits read zero.
- R6: A write with selector 2 is a prompt. It starts a fetch in every idle ring. A ring that holds an active descriptor ignores it, and its memory traffic and index stay unchanged.
- R7: A fetched descriptor whose status bit 7 is clear produces no start pulse. The ring goes idle, and its index does not change.
- R8: The start pulse lasts one cycle and carries the following: the buffer address {page_i, addr[23:0]}, the length equal to the descriptor count, and the control output equal to the full status byte.
- R9: On done, the engine writes word 0 with byte enables 0011, putting the done count in [11:0]. It then writes word 1 with byte enables 1000 and status {0, done_stat[6:0]}. The reserved bytes and the address bytes stay untouched.
- R10: Each descriptor that is closed gives exactly one pkt_done pulse for its ring. The index then advances, and the next descriptor is fetched straight away.
- R11: While master_en is low, both rings are idle, both indices read 0, and no memory request is issued. Raising master_en again does not restart a ring without a prompt.
- R12: A request keeps its address and data stable until mem_ack, which lasts one cycle. When both rings request at the same time, the receive ring is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | Ring processing enable; low clears the indices |
| page_i | input | 8 | Address bits [31:24] for all memory accesses |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 size, 2 prompt |
| reg_wdata | input | 16 | Register write data |
| ring_base_o | output | 14 | Base register readback (address bits [23:10]) |
| ring_size_o | output | 16 | Size register readback |
| ring_ptr_o | output | 16 | Ring index readback |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Word address (byte units, bits [1:0] zero) |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | One-cycle completion of the current access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rx_start | output | 1 | Receive buffer handed to the data path |
| rx_buf_addr | output | 32 | Receive buffer address |
| rx_len | output | 12 | Receive buffer length |
| rx_ctl | output | 8 | Receive descriptor status byte |
| rx_done | input | 1 | Receive frame finished |
| rx_done_cnt | input | 12 | Receive byte count to write back |
| rx_done_stat | input | 7 | Receive status flags to write back |
| rx_pkt_done | output | 1 | Receive descriptor closed |
| tx_start | output | 1 | Transmit buffer handed to the data path |
| tx_buf_addr | output | 32 | Transmit buffer address |
| tx_len | output | 12 | Transmit length |
| tx_ctl | output | 8 | Transmit descriptor status byte (control flags) |
| tx_done | input | 1 | Transmit frame finished |
| tx_done_cnt | input | 12 | Transmit count to write back |
| tx_done_stat | input | 7 | Transmit status flags to write back |
| tx_pkt_done | output | 1 | Transmit descriptor closed |

## Verification
A wrong ring index shows up at the pointer readback right after the prompt has been served. It also shows up within two memory accesses as a descriptor address in the wrong slot, and the start fields are then compared against the contents software placed there. A lost ownership check or a wrong wrap mask changes how many start pulses come before the ring goes idle. The bench counts these starts against the number of owned descriptors. A write-back with wrong byte enables or a wrong ordering becomes visible in the memory image as soon as the ring goes quiet, because corrupted reserved or address bytes differ from what was written.

// File: rtl/ring_pkg.sv
// Shared types and constants for the descriptor ring engine.
package ring_pkg;
    // Per-ring processing phases
    typedef enum logic [2:0] {
        CH_IDLE,
        CH_RD0,
        CH_RD1,
        CH_XFER,
        CH_WB0,
        CH_WB1
    } ch_state_e;

    // Memory port owner held by the arbiter until the access completes
    typedef enum logic [1:0] {
        OWN_NONE,
        OWN_RX,
        OWN_TX
    } mem_owner_e;

    localparam int          OWN_BIT    = 7;
    localparam logic [1:0]  SEL_BASE   = 2'd0;
    localparam logic [1:0]  SEL_SIZE   = 2'd1;
    localparam logic [1:0]  SEL_PROMPT = 2'd2;
endpackage

// File: rtl/ring_regs.sv
// Configuration registers: ring base, per-ring size code, prompt strobe.
// Assumes: single write strobe with selector; size codes are one of the
// thermometer values, the wrap mask is formed directly from the code.
module ring_regs import ring_pkg::*; #(
    parameter int BASE_W = 14,
    parameter int CODE_W = 4,
    parameter int REG_W  = 16,
    localparam int IDX_W = CODE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [BASE_W-1:0] base_o,
    output logic [REG_W-1:0]  size_o,
    output logic [IDX_W-1:0]  rx_mask,
    output logic [IDX_W-1:0]  tx_mask,
    output logic              prompt_o
);
    logic [BASE_W-1:0] base_q;
    logic [CODE_W-1:0] rx_code_q, tx_code_q;

    // Register writes for base and size codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            rx_code_q <= '0;
            tx_code_q <= '0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_BASE) base_q <= reg_wdata[BASE_W-1:0];
            if (reg_sel == SEL_SIZE) begin
                tx_code_q <= reg_wdata[REG_W-1 -: CODE_W];
                rx_code_q <= reg_wdata[REG_W-CODE_W-1 -: CODE_W];
            end
        end
    end

    // Readback, wrap masks and prompt decode
    always_comb begin
        base_o   = base_q;
        size_o   = {tx_code_q, rx_code_q, {(REG_W-2*CODE_W){1'b0}}};
        rx_mask  = {rx_code_q, 2'b11};
        tx_mask  = {tx_code_q, 2'b11};
        prompt_o = reg_wr && (reg_sel == SEL_PROMPT);
    end
endmodule

// File: rtl/ring_chan.sv
// One ring walker: fetches a descriptor (two word reads), checks
// ownership, hands the buffer to the data path, writes back count and
// status, advances the index modulo the ring size and fetches again.
// Assumes: memory request held until a one-cycle ack; done arrives
// only after start.
module ring_chan import ring_pkg::*; #(
    parameter int IDX_W    = 6,
    parameter int CNT_W    = 12,
    parameter int PAGE_W   = 8,
    parameter int BASE_W   = 14,
    parameter int BADDR_W  = 24,
    parameter int DW       = 32,
    parameter bit RING_SEL = 1'b0,
    localparam int STAT_W  = 7,
    localparam int BYTE_W  = 8,
    localparam int AW      = PAGE_W + BASE_W + 1 + IDX_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master_en,
    input  logic               prompt,
    input  logic [PAGE_W-1:0]  page_i,
    input  logic [BASE_W-1:0]  base_i,
    input  logic [IDX_W-1:0]   mask_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               mreq,
    output logic               mwe,
    output logic [AW-1:0]      maddr,
    output logic [DW-1:0]      mwdata,
    output logic [3:0]         mbe,
    input  logic               mack,
    input  logic [DW-1:0]      mrdata,
    output logic               start_o,
    output logic [PAGE_W+BADDR_W-1:0] buf_addr_o,
    output logic [CNT_W-1:0]   len_o,
    output logic [BYTE_W-1:0]  ctl_o,
    input  logic               done_i,
    input  logic [CNT_W-1:0]   done_cnt_i,
    input  logic [STAT_W-1:0]  done_stat_i,
    output logic               pkt_done_o
);
    ch_state_e          state;
    logic [IDX_W-1:0]   idx_q;
    logic [CNT_W-1:0]   c_cnt, r_cnt;
    logic [BADDR_W-1:0] c_addr;
    logic [BYTE_W-1:0]  c_stat;
    logic [STAT_W-1:0]  r_stat;
    logic               start_q, pkt_q;
    logic               unused_rd;

    assign unused_rd = ^mrdata[15:CNT_W];

    // Descriptor walk state machine with cached descriptor
    always_ff @(posedge clk) begin
        if (!rst_n || !master_en) begin
            state   <= CH_IDLE;
            idx_q   <= '0;
            c_cnt   <= '0;
            c_addr  <= '0;
            c_stat  <= '0;
            r_cnt   <= '0;
            r_stat  <= '0;
            start_q <= 1'b0;
            pkt_q   <= 1'b0;
        end else begin
            start_q <= 1'b0;
            pkt_q   <= 1'b0;
            case (state)
                CH_IDLE: if (prompt) state <= CH_RD0;
                CH_RD0: if (mack) begin
                    c_cnt <= mrdata[CNT_W-1:0];
                    state <= CH_RD1;
                end
                CH_RD1: if (mack) begin
                    c_addr <= mrdata[BADDR_W-1:0];
                    c_stat <= mrdata[DW-1 -: BYTE_W];
                    if (mrdata[BADDR_W+OWN_BIT]) begin
                        state   <= CH_XFER;
                        start_q <= 1'b1;
                    end else begin
                        state <= CH_IDLE;
                    end
                end
                CH_XFER: if (done_i) begin
                    r_cnt  <= done_cnt_i;
                    r_stat <= done_stat_i;
                    state  <= CH_WB0;
                end
                CH_WB0: if (mack) state <= CH_WB1;
                CH_WB1: if (mack) begin
                    pkt_q <= 1'b1;
                    idx_q <= (idx_q + IDX_W'(1)) & mask_i;
                    state <= CH_RD0;
                end
                default: state <= CH_IDLE;
            endcase
        end
    end

    // Memory request formation for the current phase
    always_comb begin
        mreq   = (state == CH_RD0) || (state == CH_RD1) ||
                 (state == CH_WB0) || (state == CH_WB1);
        mwe    = (state == CH_WB0) || (state == CH_WB1);
        maddr  = {page_i, base_i, RING_SEL, idx_q,
                  (state == CH_RD1) || (state == CH_WB1), 2'b00};
        mwdata = '0;
        mbe    = 4'b0000;
        if (state == CH_WB0) begin
            mwdata = DW'(r_cnt);
            mbe    = 4'b0011;
        end else if (state == CH_WB1) begin
            mwdata = {1'b0, r_stat, {BADDR_W{1'b0}}};
            mbe    = 4'b1000;
        end
    end

    // Data path handoff and readback
    always_comb begin
        idx_o      = idx_q;
        start_o    = start_q;
        buf_addr_o = {page_i, c_addr};
        len_o      = c_cnt;
        ctl_o      = c_stat;
        pkt_done_o = pkt_q;
    end

    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R7
    not_owned_chk: assert property (@(posedge clk) disable iff (!rst_n || !master_en)
        (state == CH_RD1 && mack && !mrdata[DW-1]) |=> (!start_o && state == CH_IDLE));

    // R10
    refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done_o |-> (mreq && !mwe && !maddr[2]));

    // R11
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (idx_o == '0 && !mreq && !start_o));
endmodule

// File: rtl/ring_mem_arb.sv
// Two-requester arbiter for the single memory port. Receive wins when
// both request from idle; the winner keeps the port until its ack.
// Assumes: each requester holds its request steady until acked.
module ring_mem_arb import ring_pkg::*; #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  master_en,
    input  logic [1:0]            c_req,
    input  logic [1:0]            c_we,
    input  logic [1:0][AW-1:0]    c_addr,
    input  logic [1:0][DW-1:0]    c_wdata,
    input  logic [1:0][3:0]       c_be,
    output logic [1:0]            c_ack,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [DW-1:0]         mem_wdata,
    output logic [3:0]            mem_be,
    input  logic                  mem_ack
);
    mem_owner_e owner;
    logic       pick_tx;

    // Select current requester: held owner first, else receive priority
    always_comb begin
        pick_tx   = (owner == OWN_TX) || (owner == OWN_NONE && !c_req[0] && c_req[1]);
        mem_req   = c_req[pick_tx];
        mem_we    = c_we[pick_tx];
        mem_addr  = c_addr[pick_tx];
        mem_wdata = c_wdata[pick_tx];
        mem_be    = c_be[pick_tx];
        c_ack     = {mem_ack && pick_tx, mem_ack && !pick_tx};
    end

    // Hold ownership while an access is outstanding
    always_ff @(posedge clk) begin
        if (!rst_n || !master_en || mem_ack) owner <= OWN_NONE;
        else if (mem_req)                    owner <= pick_tx ? OWN_TX : OWN_RX;
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !master_en)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

// File: rtl/desc_ring_engine.sv
// Top of the descriptor ring engine: registers, two ring walkers
// (receive = ring 0, transmit = ring 1) and the memory arbiter.
// Assumes: size codes are changed only while master_en is low.
module desc_ring_engine import ring_pkg::*; #(
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 12,
    parameter int PAGE_W = 8,
    parameter int BASE_W = 14,
    parameter int REG_W  = 16,
    parameter int DW     = 32,
    localparam int AW    = PAGE_W + BASE_W + IDX_W + 4,
    localparam int NRING = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [BASE_W-1:0] ring_base_o,
    output logic [REG_W-1:0]  ring_size_o,
    output logic [REG_W-1:0]  ring_ptr_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              rx_start,
    output logic [AW-1:0]     rx_buf_addr,
    output logic [CNT_W-1:0]  rx_len,
    output logic [7:0]        rx_ctl,
    input  logic              rx_done,
    input  logic [CNT_W-1:0]  rx_done_cnt,
    input  logic [6:0]        rx_done_stat,
    output logic              rx_pkt_done,
    output logic              tx_start,
    output logic [AW-1:0]     tx_buf_addr,
    output logic [CNT_W-1:0]  tx_len,
    output logic [7:0]        tx_ctl,
    input  logic              tx_done,
    input  logic [CNT_W-1:0]  tx_done_cnt,
    input  logic [6:0]        tx_done_stat,
    output logic              tx_pkt_done
);
    localparam int HALF_W = REG_W / 2;

    logic [IDX_W-1:0]              mask [NRING];
    logic [IDX_W-1:0]              idx  [NRING];
    logic                          prompt;
    logic [NRING-1:0]              c_req, c_we, c_ack, st, dn, pk;
    logic [NRING-1:0][AW-1:0]      c_addr, baddr;
    logic [NRING-1:0][DW-1:0]      c_wdata;
    logic [NRING-1:0][3:0]         c_be;
    logic [NRING-1:0][CNT_W-1:0]   len, dcnt;
    logic [NRING-1:0][7:0]         ctl;
    logic [NRING-1:0][6:0]         dstat;

    ring_regs #(.BASE_W(BASE_W), .CODE_W(IDX_W-2), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .base_o(ring_base_o), .size_o(ring_size_o),
        .rx_mask(mask[0]), .tx_mask(mask[1]), .prompt_o(prompt)
    );

    genvar g;
    generate
        for (g = 0; g < NRING; g++) begin : g_ring
            ring_chan #(
                .IDX_W(IDX_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .BASE_W(BASE_W),
                .BADDR_W(AW-PAGE_W), .DW(DW), .RING_SEL(g == 1)
            ) u_chan (
                .clk(clk), .rst_n(rst_n), .master_en(master_en), .prompt(prompt),
                .page_i(page_i), .base_i(ring_base_o), .mask_i(mask[g]),
                .idx_o(idx[g]), .mreq(c_req[g]), .mwe(c_we[g]), .maddr(c_addr[g]),
                .mwdata(c_wdata[g]), .mbe(c_be[g]), .mack(c_ack[g]), .mrdata(mem_rdata),
                .start_o(st[g]), .buf_addr_o(baddr[g]), .len_o(len[g]), .ctl_o(ctl[g]),
                .done_i(dn[g]), .done_cnt_i(dcnt[g]), .done_stat_i(dstat[g]),
                .pkt_done_o(pk[g])
            );
        end
    endgenerate

    ring_mem_arb #(.AW(AW), .DW(DW)) u_arb (
        .clk(clk), .rst_n(rst_n), .master_en(master_en),
        .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_be(c_be),
        .c_ack(c_ack), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack)
    );

    // Flatten per-ring signals onto the named ports
    always_comb begin
        ring_ptr_o = {(HALF_W-IDX_W)'(0), idx[1], (HALF_W-IDX_W)'(0), idx[0]};
        rx_start = st[0];  rx_buf_addr = baddr[0];  rx_len = len[0];  rx_ctl = ctl[0];
        tx_start = st[1];  tx_buf_addr = baddr[1];  tx_len = len[1];  tx_ctl = ctl[1];
        rx_pkt_done = pk[0];
        tx_pkt_done = pk[1];
        dn    = {tx_done, rx_done};
        dcnt  = {tx_done_cnt, rx_done_cnt};
        dstat = {tx_done_stat, rx_done_stat};
    end
endmodule

// File: tb/desc_ring_engine_tb.sv
module desc_ring_engine_tb;
    localparam int PERIOD = 10;
    // {size code, owned count, expected final receive index}
    localparam logic [19:0] VEC [6] = '{
        20'h0_03_03, 20'h0_04_00, 20'h1_05_05,
        20'h3_10_00, 20'h7_09_09, 20'hF_02_02
    };

    logic clk = 0, rst_n = 0, master_en = 0;
    logic [7:0]  page = 8'h5C;
    logic        reg_wr = 0;
    logic [1:0]  reg_sel = 0;
    logic [15:0] reg_wdata = 0;
    wire  [13:0] ring_base_o;
    wire  [15:0] ring_size_o, ring_ptr_o;
    wire         mem_req, mem_we;
    wire  [31:0] mem_addr, mem_wdata;
    wire  [3:0]  mem_be;
    logic        mem_ack = 0;
    logic [31:0] mem_rdata = 0;
    wire         rx_start, tx_start, rx_pkt_done, tx_pkt_done;
    wire  [31:0] rx_buf_addr, tx_buf_addr;
    wire  [11:0] rx_len, tx_len;
    wire  [7:0]  rx_ctl, tx_ctl;
    logic        dn_b [2];
    logic [11:0] dcnt_b [2];
    logic [6:0]  dstat_b [2];

    int checks = 0, fails = 0;
    int starts [2], pkts [2], exp_idx [2], ents [2], dly [2];
    bit hold [2], pend [2];
    logic [11:0] lat_len [2];
    logic [6:0]  lat_stat [2];
    logic [31:0] mem [256];
    logic [13:0] base_now = 0;
    int  rx_acc = 0;
    bit  arm = 0;
    logic [31:0] first_addr = 0;

    always #(PERIOD/2) clk = ~clk;

    desc_ring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .page_i(page),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ring_base_o(ring_base_o), .ring_size_o(ring_size_o), .ring_ptr_o(ring_ptr_o),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rx_start(rx_start), .rx_buf_addr(rx_buf_addr), .rx_len(rx_len), .rx_ctl(rx_ctl),
        .rx_done(dn_b[0]), .rx_done_cnt(dcnt_b[0]), .rx_done_stat(dstat_b[0]),
        .rx_pkt_done(rx_pkt_done),
        .tx_start(tx_start), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len), .tx_ctl(tx_ctl),
        .tx_done(dn_b[1]), .tx_done_cnt(dcnt_b[1]), .tx_done_stat(dstat_b[1]),
        .tx_pkt_done(tx_pkt_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] f_cnt(int r, int i);
        return 12'(r * 700 + i * 37 + 5);
    endfunction
    function automatic logic [23:0] f_adr(int r, int i);
        return 24'h300000 + 24'(r * 32768 + i * 256);
    endfunction
    function automatic logic [7:0] f_st(int i);
        return 8'h80 | 8'(i % 32);
    endfunction

    // Memory model: one-cycle ack at negedge, byte-enabled writes, address check (R2, R3)
    always @(negedge clk) begin
        if (mem_ack) mem_ack <= 0;
        else if (mem_req) begin
            chk(mem_addr[31:10] == {page, base_now}, "R2 address page/base", mem_addr, {page, base_now, 10'h0});
            if (arm) begin first_addr = mem_addr; arm = 0; end
            if (!mem_addr[9]) rx_acc++;
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
            end else mem_rdata <= mem[mem_addr[9:2]];
            mem_ack <= 1;
        end
    end

    // Frame data path model per ring; checks start fields (R8, R3)
    always @(negedge clk) begin
        for (int r = 0; r < 2; r++) begin
            logic st_now;
            logic [31:0] ba;
            logic [11:0] ln;
            logic [7:0]  ct;
            st_now = r ? tx_start : rx_start;
            ba = r ? tx_buf_addr : rx_buf_addr;
            ln = r ? tx_len : rx_len;
            ct = r ? tx_ctl : rx_ctl;
            if (dn_b[r]) dn_b[r] = 0;
            if (st_now) begin
                chk(ba == {page, f_adr(r, exp_idx[r])}, "R8 buffer address", ba, {page, f_adr(r, exp_idx[r])});
                chk({ct, ln} == {f_st(exp_idx[r]), f_cnt(r, exp_idx[r])}, "R8 ctl/len",
                    {12'h0, ct, ln}, {12'h0, f_st(exp_idx[r]), f_cnt(r, exp_idx[r])});
                lat_len[r]  = ln ^ 12'h0F0;
                lat_stat[r] = 7'(exp_idx[r]) ^ 7'h2A;
                exp_idx[r]  = (exp_idx[r] + 1) % ents[r];
                starts[r]++;
                pend[r] = 1;
                dly[r]  = 3;
            end else if (pend[r] && !hold[r]) begin
                if (dly[r] == 0) begin
                    dn_b[r] = 1; dcnt_b[r] = lat_len[r]; dstat_b[r] = lat_stat[r]; pend[r] = 0;
                end else dly[r]--;
            end
        end
        if (rx_pkt_done) pkts[0]++;
        if (tx_pkt_done) pkts[1]++;
    end

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        if (sel == 2'd0) base_now = d[13:0];
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic restart();
        @(negedge clk); master_en = 0;
        @(negedge clk); master_en = 1;
        for (int r = 0; r < 2; r++) begin starts[r] = 0; pkts[r] = 0; exp_idx[r] = 0; end
        for (int w = 0; w < 256; w++) mem[w] = 32'h0;
    endtask

    task automatic fill(input int r, input int i);
        mem[r*128 + i*2]     = {16'hBEEF, 4'h0, f_cnt(r, i)};
        mem[r*128 + i*2 + 1] = {f_st(i), f_adr(r, i)};
    endtask

    function automatic bit wb_ok(input int r, input int n);
        bit ok = 1;
        for (int i = 0; i < n; i++) begin
            if (mem[r*128 + i*2] != {16'hBEEF, 4'h0, f_cnt(r, i) ^ 12'h0F0}) ok = 0;
            if (mem[r*128 + i*2 + 1] != {1'b0, 7'(i) ^ 7'h2A, f_adr(r, i)}) ok = 0;
        end
        return ok;
    endfunction

    task automatic wait_quiet();
        int q = 0;
        for (int k = 0; k < 20000 && q < 6; k++) begin
            @(posedge clk); #1;
            if (!mem_req && !rx_start && !tx_start && !pend[0] && !pend[1]) q++;
            else q = 0;
        end
        if (q < 6) chk(0, "wait for idle", 0, 1);
    endtask

    task automatic wait_starts(input int r, input int n);
        for (int k = 0; k < 2000 && starts[r] < n; k++) begin @(posedge clk); #1; end
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 2; r++) begin
            dn_b[r] = 0; dcnt_b[r] = 0; dstat_b[r] = 0; hold[r] = 0; pend[r] = 0;
            ents[r] = 4; starts[r] = 0; pkts[r] = 0; exp_idx[r] = 0; dly[r] = 0;
        end
        for (int w = 0; w < 256; w++) mem[w] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ring_ptr_o == 16'h0, "R1 pointer", ring_ptr_o, 0);
        chk({ring_base_o, ring_size_o} == 30'h0, "R1 base/size", {ring_base_o, ring_size_o}, 0);
        chk(!mem_req && !rx_start && !tx_start, "R1 idle outputs", {mem_req, rx_start, tx_start}, 0);

        // Table walk: size code, owned descriptors, final index (R4, R7, R9, R10)
        for (int v = 0; v < 6; v++) begin
            logic [3:0] code;
            int n, ex;
            code = VEC[v][19:16]; n = VEC[v][15:8]; ex = VEC[v][7:0];
            @(negedge clk); master_en = 0;
            reg_write(2'd1, {4'h0, code, 8'h00});
            ents[0] = {code, 2'b11} + 1; ents[1] = 4;
            restart();
            for (int i = 0; i < n; i++) fill(0, i);
            reg_write(2'd2, 16'h0);
            wait_quiet();
            chk(ring_ptr_o[5:0] == 6'(ex), "R4 receive index after wrap", ring_ptr_o, ex);
            chk(starts[0] == n, "R10 start count", starts[0], n);
            chk(pkts[0] == n, "R10 pkt_done count", pkts[0], n);
            chk(wb_ok(0, n), "R9 write-back image", 0, 1);
            chk(ring_ptr_o[13:8] == 0 && starts[1] == 0, "R7 unowned transmit ring", {ring_ptr_o, 16'(starts[1])}, 0);
        end

        // Base, transmit offset, pointer layout, receive priority (R2, R3, R5, R12)
        @(negedge clk); master_en = 0;
        reg_write(2'd0, 16'h02A5);
        reg_write(2'd1, 16'h3100);
        ents[0] = 8; ents[1] = 16;
        restart();
        for (int i = 0; i < 3; i++) fill(0, i);
        for (int i = 0; i < 2; i++) fill(1, i);
        arm = 1;
        reg_write(2'd2, 16'h1234);
        wait_quiet();
        chk(first_addr[9:0] == 10'h0, "R12 receive served first", first_addr, {page, 14'h02A5, 10'h0});
        chk(ring_ptr_o == 16'h0203, "R5 pointer layout", ring_ptr_o, 16'h0203);
        chk(starts[1] == 2 && pkts[1] == 2, "R3 transmit ring at +512", starts[1], 2);
        chk(wb_ok(1, 2) && wb_ok(0, 3), "R9 write-back both rings", 0, 1);
        chk(ring_base_o == 14'h02A5 && ring_size_o == 16'h3100, "R2 register readback",
            {ring_base_o, ring_size_o}, {14'h02A5, 16'h3100});

        // Prompt while active is ignored (R6)
        restart();
        fill(0, 0);
        hold[0] = 1;
        reg_write(2'd2, 16'h0);
        wait_starts(0, 1);
        begin
            int acc0;
            acc0 = rx_acc;
            reg_write(2'd2, 16'hFFFF);
            repeat (20) @(negedge clk);
            chk(rx_acc == acc0, "R6 no receive traffic on prompt while active", rx_acc, acc0);
            chk(ring_ptr_o[5:0] == 0 && starts[0] == 1, "R6 receive index kept", ring_ptr_o, 0);
        end
        hold[0] = 0;
        wait_quiet();
        chk(ring_ptr_o[5:0] == 1 && starts[0] == 1, "R6 single descriptor processed", ring_ptr_o, 1);

        // Master disable mid-run (R11)
        restart();
        fill(0, 0); fill(0, 1);
        reg_write(2'd2, 16'h0);
        wait_starts(0, 2);
        hold[0] = 1;
        chk(ring_ptr_o[5:0] == 1, "R11 index before disable", ring_ptr_o, 1);
        @(negedge clk); master_en = 0;
        @(negedge clk);
        chk(ring_ptr_o == 0 && !mem_req, "R11 disabled state", {ring_ptr_o, 15'h0, mem_req}, 0);
        pend[0] = 0; hold[0] = 0;
        @(negedge clk); master_en = 1;
        repeat (10) @(negedge clk);
        chk(!mem_req && pkts[0] == 1, "R11 no restart without prompt", {mem_req, 16'(pkts[0])}, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule